// File: doc/BRIEF.md
# Link Training Sequencer

This block runs the two-stage bring-up of a multi-lane serial display link. It tells the lane pattern generators which pattern to send and sets the per-lane drive level (swing and emphasis). It also holds the conversation with the sink through an abstract command channel. In the first stage the lanes carry a constant unscrambled clock-recovery symbol (data 0x4A, D10.2). In the second stage they carry one of two unscrambled alignment patterns, which lets the sink equalize, find symbol boundaries and deskew the lanes.

Each iteration of a stage works in a fixed order. The block writes the link configuration to the sink, waits a programmed number of reference cycles, and reads the sink's status. If every active lane reports success, the stage is done. If not, the block reads the sink's requested drive level, applies it, and tries again. When the sink keeps asking for the drive level that is already applied, the block gives up after four failed attempts and raises a failure flag. A higher layer can then retry with fewer lanes or a lower rate. Once training succeeds, the lanes switch to video with the drive level unchanged. The block then waits for video to be present and sends one wake-up write to the sink.

The command channel is valid/ready. The block raises `cmd_valid` and holds the address, data and direction steady until the sink answers with `cmd_ready`. For reads, `cmd_rdata` must be valid in the same cycle as `cmd_ready`. The sink may apply back-pressure for any number of cycles. The block has no other buffering.

Top module: `ltrn_seq`

## Requirements
- R1: After reset the outputs are as follows: `pattern` is 0, `drive` is 0, `cmd_valid` is 0, `trained` is 0 and `failed` is 0.
- R2: A `start` pulse does three things. It latches `lane_count`, `link_rate` and `tps3_ok`, clears `drive` to 0, and enters clock recovery with `pattern` = 1. The pattern codes are 0 for video/idle, 1 for the D10.2 clock-recovery symbol, 2 for alignment pattern A and 3 for alignment pattern B.
- R3: Every iteration issues three commands in order. First is a configuration write to address 0x0100, with data bits [7:0] = rate, [10:8] = lane count, [12:11] = pattern code and [31:16] = drive. Second is a wait. Third is a status read from 0x0202. The read request appears exactly `wait_cycles`+1 cycles after the write is accepted.
- R4: Status bit i (i in 0..3) marks lane i done for clock recovery. Bit 4+i marks lane i done for alignment. A stage succeeds when the bits of all lanes below the latched lane count are set. Bits of inactive lanes are ignored.
- R5: When a status read shows the stage has not succeeded, the block reads the requested drive from address 0x0206 (bits [15:0]). If the requested value differs, it is applied to `drive` and used in the next configuration write.
- R6: The block counts consecutive failed attempts whose requested drive equals the applied drive. On the fourth such attempt it stops with `failed` = 1. The count restarts when the request differs from the applied drive, and when the block moves into the alignment stage.
- R7: The alignment stage uses `pattern` = 3 when `tps3_ok` was latched as 1, and 2 otherwise.
- R8: `drive` does not change when clock recovery moves into alignment, or when alignment moves into video.
- R9: When alignment succeeds, `trained` becomes 1 and `pattern` becomes 0. The write of data 1 to address 0x0600 is issued only after `video_active` is 1, and only once.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_write`, `cmd_addr` and `cmd_wdata` hold their values.
- R11: After a failure, `pattern` is 0, `trained` is 0 and no commands are issued until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin training (taken when idle, trained or failed) |
| lane_count | input | 3 | Active lanes: 1, 2 or 4 |
| link_rate | input | 8 | Rate code passed to the sink |
| tps3_ok | input | 1 | Alignment pattern B supported |
| wait_cycles | input | 16 | Sink read interval in reference cycles |
| video_active | input | 1 | Video data is present on the link |
| cmd_valid | output | 1 | Command request |
| cmd_ready | input | 1 | Command accepted / read data valid |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | 16 | Sink register address |
| cmd_wdata | output | 32 | Write data |
| cmd_rdata | input | 32 | Read data, valid with cmd_ready |
| pattern | output | 2 | Pattern code for the lane generators |
| drive | output | 16 | Per-lane drive, 4 bits per lane |
| trained | output | 1 | Training complete, video may be sent |
| failed | output | 1 | Training gave up |

## Verification
The hardest case to reach is the retry counter restarting in the middle of a run of identical requests. A simple sink either succeeds or always repeats itself, and neither case shows the restart. The bench's model sink therefore takes a per-read mask that decides whether each drive request repeats the applied value or moves to a new one. One request changes after three repeats, so the expected failure comes after eight status reads instead of four. A stalling sink that holds off `cmd_ready` for several cycles exercises the command hold rule. Sweeps over wait interval and lane count exercise the interval timing and the masking of inactive lanes.

// File: rtl/ltrn_pkg.sv
package ltrn_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WR_CFG, ST_WAIT, ST_RD_STAT, ST_RD_ADJ,
    ST_VID_WAIT, ST_WAKE, ST_LIVE, ST_FAIL
  } ltrn_state_t;

  localparam logic [1:0] PAT_VIDEO = 2'd0;
  localparam logic [1:0] PAT_CLKREC = 2'd1;
  localparam logic [1:0] PAT_ALIGN_A = 2'd2;
  localparam logic [1:0] PAT_ALIGN_B = 2'd3;
endpackage

// File: rtl/ltrn_timer.sv
module ltrn_timer #(
  parameter int W_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W_W-1:0] load_val,
  output logic           expired
);
  logic [W_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0) && !load;

  // R3: the interval shrinks by exactly one per cycle once loaded
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ltrn_retry.sv
module ltrn_retry #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic exhaust
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign exhaust = bump && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (bump && !exhaust) cnt <= cnt + 1'b1;
  end

  // R6: the repeat count never reaches the limit itself
  assert_retry_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));
endmodule

// File: rtl/ltrn_seq.sv
module ltrn_seq #(
  parameter int LANES       = 4,
  parameter int DRV_W       = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int WAIT_W      = 16,
  parameter int RETRY_LIMIT = 4,
  parameter logic [ADDR_W-1:0] ADDR_CFG  = 16'h0100,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 16'h0202,
  parameter logic [ADDR_W-1:0] ADDR_ADJ  = 16'h0206,
  parameter logic [ADDR_W-1:0] ADDR_PWR  = 16'h0600
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2:0]               lane_count,
  input  logic [7:0]               link_rate,
  input  logic                     tps3_ok,
  input  logic [WAIT_W-1:0]        wait_cycles,
  input  logic                     video_active,
  output logic                     cmd_valid,
  input  logic                     cmd_ready,
  output logic                     cmd_write,
  output logic [ADDR_W-1:0]        cmd_addr,
  output logic [DATA_W-1:0]        cmd_wdata,
  input  logic [DATA_W-1:0]        cmd_rdata,
  output logic [1:0]               pattern,
  output logic [LANES*DRV_W-1:0]   drive,
  output logic                     trained,
  output logic                     failed
);
  import ltrn_pkg::*;

  localparam int DRV_BITS = LANES * DRV_W;
  localparam int DRV_LSB  = 16;

  ltrn_state_t state;
  logic [2:0]  lanes_q;
  logic [7:0]  rate_q;
  logic        tps3_q;
  logic        stage_eq;
  logic [LANES-1:0] lane_mask;
  logic [LANES-1:0] stat_cr, stat_eq;
  logic [DRV_BITS-1:0] drv_req;
  logic        stage_ok, req_same, take_start, acc;
  logic        t_load, t_exp, r_clr, r_bump, r_exh;
  logic [1:0]  train_pat;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i] = (32'(i) < {29'd0, lanes_q});
  end

  assign stat_cr  = cmd_rdata[LANES-1:0];
  assign stat_eq  = cmd_rdata[LANES +: LANES];
  assign drv_req  = cmd_rdata[DRV_BITS-1:0];
  assign stage_ok = stage_eq ? ((stat_eq & lane_mask) == lane_mask)
                             : ((stat_cr & lane_mask) == lane_mask);
  assign req_same = (drv_req == drive);
  assign acc      = cmd_valid && cmd_ready;
  assign take_start = start && (state == ST_IDLE || state == ST_FAIL ||
                                state == ST_VID_WAIT || state == ST_LIVE);
  assign train_pat = stage_eq ? (tps3_q ? PAT_ALIGN_B : PAT_ALIGN_A) : PAT_CLKREC;

  assign t_load = (state == ST_WR_CFG) && cmd_ready;
  assign r_clr  = take_start || ((state == ST_RD_STAT) && cmd_ready && stage_ok) ||
                  ((state == ST_RD_ADJ) && cmd_ready && !req_same);
  assign r_bump = (state == ST_RD_ADJ) && cmd_ready && req_same;

  ltrn_timer #(.W_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(wait_cycles), .expired(t_exp)
  );

  ltrn_retry #(.LIMIT(RETRY_LIMIT)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr(r_clr), .bump(r_bump), .exhaust(r_exh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lanes_q  <= '0;
      rate_q   <= '0;
      tps3_q   <= 1'b0;
      stage_eq <= 1'b0;
      drive    <= '0;
    end else if (take_start) begin
      lanes_q  <= lane_count;
      rate_q   <= link_rate;
      tps3_q   <= tps3_ok;
      stage_eq <= 1'b0;
      drive    <= '0;
      state    <= ST_WR_CFG;
    end else begin
      unique case (state)
        ST_WR_CFG:   if (cmd_ready) state <= ST_WAIT;
        ST_WAIT:     if (t_exp) state <= ST_RD_STAT;
        ST_RD_STAT: if (cmd_ready) begin
          if (!stage_ok)     state <= ST_RD_ADJ;
          else if (stage_eq) state <= ST_VID_WAIT;
          else begin
            stage_eq <= 1'b1;
            state    <= ST_WR_CFG;
          end
        end
        ST_RD_ADJ: if (cmd_ready) begin
          if (!req_same) begin
            drive <= drv_req;
            state <= ST_WR_CFG;
          end else if (r_exh) state <= ST_FAIL;
          else                state <= ST_WR_CFG;
        end
        ST_VID_WAIT: if (video_active) state <= ST_WAKE;
        ST_WAKE:     if (cmd_ready) state <= ST_LIVE;
        default:     ;
      endcase
    end
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd_write = 1'b0;
    cmd_addr  = '0;
    cmd_wdata = '0;
    unique case (state)
      ST_WR_CFG: begin
        cmd_valid = 1'b1;
        cmd_write = 1'b1;
        cmd_addr  = ADDR_CFG;
        cmd_wdata[7:0]   = rate_q;
        cmd_wdata[10:8]  = lanes_q;
        cmd_wdata[12:11] = train_pat;
        cmd_wdata[DRV_LSB +: DRV_BITS] = drive;
      end
      ST_RD_STAT: begin cmd_valid = 1'b1; cmd_addr = ADDR_STAT; end
      ST_RD_ADJ:  begin cmd_valid = 1'b1; cmd_addr = ADDR_ADJ;  end
      ST_WAKE: begin
        cmd_valid = 1'b1;
        cmd_write = 1'b1;
        cmd_addr  = ADDR_PWR;
        cmd_wdata = DATA_W'(1);
      end
      default: ;
    endcase
  end

  assign pattern = (state == ST_WR_CFG || state == ST_WAIT || state == ST_RD_STAT ||
                    state == ST_RD_ADJ) ? train_pat : PAT_VIDEO;
  assign trained = (state == ST_VID_WAIT || state == ST_WAKE || state == ST_LIVE);
  assign failed  = (state == ST_FAIL);

  // R10: a stalled command keeps its request and payload
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                   $stable(cmd_wdata) && $stable(cmd_write)));
  // R8: drive untouched on entry to alignment and on entry to video
  assert_drive_into_eq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stage_eq) && !$past(take_start)) |-> $stable(drive));
  assert_drive_into_video_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trained) |-> $stable(drive));
  // R9: wake-up write only once trained
  assert_wake_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr == ADDR_PWR) |-> trained);
  // R11: success and failure are exclusive
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(trained && failed));
  // R2: configuration writes only happen with a training pattern on the lanes
  assert_pat_on_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_addr == ADDR_CFG) |-> (pattern != PAT_VIDEO));
endmodule

// File: tb/ltrn_seq_test.sv
module ltrn_seq_test;
  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [2:0] lane_count = 3'd4;
  logic [7:0] link_rate = 8'h14;
  logic tps3_ok = 1;
  logic [15:0] wait_cycles = 16'd2;
  logic video_active = 0;
  logic cmd_valid, cmd_write, cmd_ready;
  logic [15:0] cmd_addr;
  logic [31:0] cmd_wdata, cmd_rdata;
  logic [1:0] pattern;
  logic [15:0] drive;
  logic trained, failed;

  always #5 clk = ~clk;

  ltrn_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_count(lane_count),
    .link_rate(link_rate), .tps3_ok(tps3_ok), .wait_cycles(wait_cycles),
    .video_active(video_active), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .pattern(pattern), .drive(drive),
    .trained(trained), .failed(failed)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // model sink state
  int n_cfg, n_stat, n_adj, n_wake, t_ack, last_gap, stable_bad, hold_n, sink_delay;
  int cr_fail_left, eq_fail_left;
  bit need_gap;
  logic [31:0] last_cfg, wake_data, cap_w;
  logic [15:0] cap_a, adj_chg;
  logic [3:0] ok_bits, bad_bits;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sink_clear();
    n_cfg = 0; n_stat = 0; n_adj = 0; n_wake = 0; last_gap = -1; stable_bad = 0;
    need_gap = 0; adj_chg = 0; cr_fail_left = 0; eq_fail_left = 0; sink_delay = 0;
    ok_bits = 4'hF; bad_bits = 4'h0; wake_data = 0; last_cfg = 0;
  endtask

  task automatic serve();
    logic [15:0] cur;
    cmd_rdata = 0;
    if (cmd_addr == 16'h0100) begin
      last_cfg = cmd_wdata; n_cfg++; t_ack = cyc + 1; need_gap = 1;
    end else if (cmd_addr == 16'h0202) begin
      n_stat++;
      if (pattern == 2'd1) begin
        if (cr_fail_left > 0) begin cr_fail_left--; cmd_rdata[3:0] = bad_bits; end
        else cmd_rdata[3:0] = ok_bits;
      end else begin
        if (eq_fail_left > 0) begin eq_fail_left--; cmd_rdata[7:4] = bad_bits; end
        else cmd_rdata[7:4] = ok_bits;
        cmd_rdata[3:0] = ok_bits;
      end
    end else if (cmd_addr == 16'h0206) begin
      cur = last_cfg[31:16];
      cmd_rdata[15:0] = adj_chg[n_adj] ? cur + 16'h1111 : cur;
      n_adj++;
    end else if (cmd_addr == 16'h0600) begin
      n_wake++; wake_data = cmd_wdata;
    end
  endtask

  initial begin
    cmd_ready = 0; cmd_rdata = 0; hold_n = 0;
    sink_clear();
    forever begin
      @(negedge clk);
      if (cmd_ready) begin cmd_ready = 0; hold_n = 0; end
      else if (cmd_valid) begin
        if (hold_n == 0) begin
          cap_a = cmd_addr; cap_w = cmd_wdata;
          if (cmd_addr == 16'h0202 && need_gap) begin last_gap = cyc - t_ack; need_gap = 0; end
        end else if (cmd_addr !== cap_a || cmd_wdata !== cap_w) stable_bad++;
        if (hold_n < sink_delay) hold_n++;
        else begin serve(); cmd_ready = 1; end
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end();
    int k = 0;
    while (!trained && !failed && k < 20000) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(pattern == 0 && drive == 0 && !cmd_valid && !trained && !failed, "R1 reset",
        {pattern, drive, 3'b0, cmd_valid, trained, failed}, 0);

    // sweep: wait interval x lane count, immediate success, inactive lanes zero
    for (int w = 0; w < 4; w++) begin
      for (int li = 0; li < 3; li++) begin
        sink_clear();
        lane_count = 3'(1 << li);
        ok_bits = 4'((1 << (1 << li)) - 1);
        wait_cycles = 16'(w);
        link_rate = 8'(8'h06 + w);
        tps3_ok = w[0];
        pulse_start();
        wait_end();
        chk(trained, "R4 active-lane-only status", trained, 1);
        chk(last_gap == w + 1, "R3 read interval", last_gap, w + 1);
        chk(last_cfg[7:0] == 8'(8'h06 + w) && last_cfg[10:8] == 3'(1 << li), "R3 cfg fields",
            last_cfg[10:0], {3'(1 << li), 8'(8'h06 + w)});
        chk(last_cfg[12:11] == (w[0] ? 2'd3 : 2'd2), "R7 align pattern", last_cfg[12:11],
            w[0] ? 3 : 2);
        chk(n_cfg == 2 && n_stat == 2 && n_adj == 0, "R3 command count", n_cfg * 16 + n_stat, 16'h22);
        chk(last_cfg[31:16] == 0 && pattern == 0, "R2 drive cleared / R9 video pattern",
            {last_cfg[31:16], 2'b0, pattern}, 0);
      end
    end

    // scenario B: changing requests in clock recovery, one repeat in alignment, stalling sink
    sink_clear();
    lane_count = 3'd4; tps3_ok = 1; wait_cycles = 3; link_rate = 8'h0A;
    sink_delay = 2; cr_fail_left = 2; eq_fail_left = 1; bad_bits = 4'b0111;
    adj_chg = 16'b0011;
    pulse_start();
    @(negedge clk); @(negedge clk);
    chk(pattern == 2'd1, "R2 clock-recovery pattern", pattern, 1);
    wait_end();
    chk(trained && !failed, "R6 single repeat tolerated", {trained, failed}, 2);
    chk(drive == 16'h2222, "R5 applied request", drive, 16'h2222);
    chk(last_cfg[31:16] == 16'h2222 && last_cfg[12:11] == 2'd3, "R8 drive kept into alignment",
        last_cfg[31:11], {16'h2222, 5'd3});
    chk(n_cfg == 5 && n_stat == 5 && n_adj == 3, "R5 iteration count",
        n_cfg * 256 + n_stat * 16 + n_adj, 16'h553);
    chk(stable_bad == 0, "R10 payload held while stalled", stable_bad, 0);
    repeat (20) @(negedge clk);
    chk(n_wake == 0 && pattern == 0, "R9 no wake before video", n_wake, 0);
    video_active = 1;
    repeat (12) @(negedge clk);
    chk(n_wake == 1 && wake_data == 1, "R9 wake write", n_wake * 16 + wake_data, 16'h11);
    chk(drive == 16'h2222, "R8 drive kept into video", drive, 16'h2222);
    video_active = 0;

    // scenario C: sink always repeats, lane 3 never done
    sink_clear();
    wait_cycles = 1; cr_fail_left = 1000; bad_bits = 4'b0111;
    pulse_start();
    wait_end();
    chk(failed && !trained, "R6 fail after four repeats", {trained, failed}, 1);
    chk(n_stat == 4 && n_cfg == 4, "R6 attempts before fail", n_stat, 4);
    repeat (40) @(negedge clk);
    chk(n_cfg == 4 && n_stat == 4 && !cmd_valid && pattern == 0, "R11 quiet after failure",
        n_cfg * 16 + n_stat, 16'h44);

    // scenario D: request changes after three repeats -> counter restarts
    sink_clear();
    wait_cycles = 0; cr_fail_left = 1000; bad_bits = 4'b0000;
    adj_chg = 16'b0000_1000;
    pulse_start();
    wait_end();
    chk(failed, "R6 fail after restart", failed, 1);
    chk(n_stat == 8, "R6 counter restart on new request", n_stat, 8);
    chk(drive == 16'h1111, "R5 changed request applied", drive, 16'h1111);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule